// File: doc/BRIEF.md
# NAND flash byte transfer controller

This block moves a counted run of bytes between an 8-bit NAND flash data bus and a local 16-bit word memory. Software programs a configuration word, a word pointer and a byte count over a small register bus, then sets a self-clearing go bit. In master mode the block produces the read or write strobe for every byte with a programmable width. In slave mode it stays passive and captures one byte on each selected edge of the ready/busy pin. When every byte has moved, the go bit clears and an interrupt can be raised.

Buffered transfers pack two bytes into each memory word, the first byte in the upper half. Unbuffered transfers move one byte between the bus and a pair of byte registers. Command and address latching, chip enable and error correction are not part of this block.

Register map (word addresses on `reg_addr`): 0 configuration, 1 control/status, 2 pointer, 3 length, 4 input byte (read only), 5 output byte. Configuration bits: [5:0] strobe timing value W, 6 interrupt enable, 7 bus float, 8 slave mode, 9 slave rising edge. Control bits: 0 buffered mode, 1 go, 2 direction (1 = from flash), 4 ready status (read only). Writes to configuration, control, pointer, length and output byte take effect only while the block is idle.

Top module: `nand_xfer_ctrl`

## Requirements
- R1: After reset, configuration, pointer, length, input byte and output byte read 0. The control word reads 0x0010 while `nf_rb` is high. `irq` is 0, `nf_re_n` and `nf_we_n` are 1, and `nf_doe` is 1.
- R2: In master mode every byte takes one strobe that is low for W+1 clocks and high for W+1 clocks. The strobe is `nf_re_n` when control bit 2 is 1 and `nf_we_n` when it is 0. A transfer of N bytes keeps control bit 1 at 1 for N·2·(W+1) clocks.
- R3: In a buffered read, byte k is sampled from `nf_din` on the clock edge where `nf_re_n` rises. It is written to word pointer+k/2, to the upper half (`mem_be`=10) when k is even and to the lower half (`mem_be`=01) when k is odd. The other half of the word is left unchanged, and memory is written only while a transfer runs.
- R4: In a buffered write, byte k is taken from the same word and half as in R3. It is held on `nf_dout` for its whole strobe period, with one `nf_we_n` pulse per byte. `nf_doe` is 1 while the write runs.
- R5: Control bit 1 clears by itself after the last byte. At that point `irq` goes to 1 if configuration bit 6 is set. Any write to the control register clears `irq`.
- R6: Setting go with a buffered length of 0 completes at once. Go reads 0 on the next clock, no strobe is produced, and `irq` rises as for a normal transfer.
- R7: With control bit 0 clear, exactly one byte moves whatever the length register holds, and memory is not written. A read places the byte in the input byte register (address 4). A write sends the output byte register (address 5).
- R8: With configuration bit 7 set, `nf_doe` is 0 except during a master write. With the bit clear, `nf_doe` is 1.
- R9: Control bit 4 equals `nf_rb` delayed through a two-flop synchronizer: a change on `nf_rb` shows after the second rising clock edge.
- R10: In slave mode, each synchronized edge of `nf_rb` captures `nf_din` into memory in the order of R3. The edge is rising when configuration bit 9 is set and falling when it is clear. Go clears after length bytes, and `nf_re_n`/`nf_we_n` stay high.
- R11: With configuration bit 6 clear, a completed transfer leaves `irq` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RAW | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| mem_addr | output | AW | Memory word address |
| mem_we | output | 1 | Memory write enable |
| mem_be | output | 2 | Memory byte enables, bit 1 = upper half |
| mem_wdata | output | 16 | Memory write data (byte copied to both halves) |
| mem_rdata | input | 16 | Memory read data, valid in the same cycle as `mem_addr` |
| nf_din | input | 8 | Flash data bus input |
| nf_dout | output | 8 | Flash data bus output |
| nf_doe | output | 1 | Flash data bus output enable |
| nf_re_n | output | 1 | Flash read strobe, active low |
| nf_we_n | output | 1 | Flash write strobe, active low |
| nf_rb | input | 1 | Flash ready/busy (low = busy), asynchronous |
| irq | output | 1 | Transfer-complete interrupt request |

## Verification
A wrong phase counter or byte counter shows at the ports within one strobe period. Pulse widths change, go stays up too long or drops early, and the clock count from go to idle no longer equals N·2·(W+1). A wrong lane or pointer state shows on the first odd byte or the first word crossing, as misplaced memory halves or as a wrong byte sent on `nf_dout`. A broken synchronizer or edge selector shows as a ready status change at the wrong clock, or as slave bytes captured on the wrong half of an `nf_rb` toggle.

// File: rtl/nfx_pkg.sv
package nfx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2,
    ST_SLV  = 2'd3
  } nfx_state_e;

  // register word addresses
  localparam int A_CFG  = 0;
  localparam int A_CTL  = 1;
  localparam int A_PTR  = 2;
  localparam int A_LEN  = 3;
  localparam int A_DIN  = 4;
  localparam int A_DOUT = 5;

  // configuration bit positions (timing value occupies the low bits)
  localparam int B_IRQEN = 6;
  localparam int B_FLOAT = 7;
  localparam int B_SLAVE = 8;
  localparam int B_RISE  = 9;

  // control bit positions
  localparam int B_BUF = 0;
  localparam int B_GO  = 1;
  localparam int B_DIR = 2;
  localparam int B_RDY = 4;

  // big-endian lane: even byte index in the upper half
  function automatic logic [7:0] lane_pick(input logic [15:0] word, input logic odd);
    return odd ? word[7:0] : word[15:8];
  endfunction

  function automatic logic [1:0] lane_mask(input logic odd);
    return odd ? 2'b01 : 2'b10;
  endfunction

  // clocks spent in one strobe phase
  function automatic int unsigned phase_len(input int unsigned w);
    return w + 1;
  endfunction

endpackage

// File: rtl/nfx_rb_sync.sv
module nfx_rb_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic rb_async,
  output logic rb_sync,
  output logic rb_rise,
  output logic rb_fall
);
  logic meta_q, sync_q, prev_q;

  // pulled-up line: every stage resets high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= rb_async;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rb_sync = sync_q;
  assign rb_rise = sync_q & ~prev_q;
  assign rb_fall = ~sync_q & prev_q;
endmodule

// File: rtl/nfx_phase_timer.sv
module nfx_phase_timer #(
  parameter int WSW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic [WSW-1:0] limit,
  output logic           term
);
  logic [WSW-1:0] cnt_q;

  assign term = (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else          cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/nand_xfer_ctrl.sv
module nand_xfer_ctrl
  import nfx_pkg::*;
#(
  parameter int AW  = 8,
  parameter int LW  = 16,
  parameter int WSW = 6,
  parameter int RAW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [15:0]    reg_wdata,
  output logic [15:0]    reg_rdata,
  output logic [AW-1:0]  mem_addr,
  output logic           mem_we,
  output logic [1:0]     mem_be,
  output logic [15:0]    mem_wdata,
  input  logic [15:0]    mem_rdata,
  input  logic [7:0]     nf_din,
  output logic [7:0]     nf_dout,
  output logic           nf_doe,
  output logic           nf_re_n,
  output logic           nf_we_n,
  input  logic           nf_rb,
  output logic           irq
);
  localparam int CFGW = B_RISE + 1;

  // configuration state
  logic [WSW-1:0] cfg_ws;
  logic           cfg_irq_en, cfg_float, cfg_slave, cfg_rise;
  // control and data registers
  logic           ctl_buf, ctl_rd;
  logic [AW-1:0]  ptr_reg, ptr_cur;
  logic [LW-1:0]  len_reg, remain;
  logic [7:0]     din_reg, dout_reg, wbyte;
  logic           odd, strobe_n, irq_q;
  nfx_state_e     st;

  // synchronizer and phase timer
  logic rb_s, rb_rise, rb_fall, term, tmr_clr;

  nfx_rb_sync u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .rb_async (nf_rb),
    .rb_sync  (rb_s),
    .rb_rise  (rb_rise),
    .rb_fall  (rb_fall)
  );

  assign tmr_clr = (st == ST_IDLE) || (st == ST_SLV) || term;

  nfx_phase_timer #(.WSW(WSW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .limit (cfg_ws),
    .term  (term)
  );

  // named internal events
  logic          busy;
  logic          wr_idle, wr_ctl;
  logic          ev_start, ev_go, ev_zero, ev_capture, ev_advance, ev_finish;
  logic          slv_edge;
  logic [LW-1:0] start_cnt;

  assign busy      = (st != ST_IDLE);
  assign wr_idle   = reg_we && !busy;
  assign wr_ctl    = reg_we && (reg_addr == RAW'(A_CTL));
  assign start_cnt = reg_wdata[B_BUF] ? len_reg : LW'(1);
  assign ev_start  = wr_idle && (reg_addr == RAW'(A_CTL)) && reg_wdata[B_GO];
  assign ev_zero   = ev_start && (start_cnt == '0);
  assign ev_go     = ev_start && (start_cnt != '0);
  assign slv_edge  = cfg_rise ? rb_rise : rb_fall;
  assign ev_advance = ((st == ST_LOW) && term) || ((st == ST_SLV) && slv_edge);
  assign ev_capture = ((st == ST_LOW) && term && ctl_rd) || ((st == ST_SLV) && slv_edge);
  assign ev_finish  = ev_zero
                    || ((st == ST_HIGH) && term && (remain == '0))
                    || ((st == ST_SLV) && slv_edge && (remain == LW'(1)));

  // register file
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_ws     <= '0;
      cfg_irq_en <= 1'b0;
      cfg_float  <= 1'b0;
      cfg_slave  <= 1'b0;
      cfg_rise   <= 1'b0;
      ctl_buf    <= 1'b0;
      ctl_rd     <= 1'b0;
      ptr_reg    <= '0;
      len_reg    <= '0;
      dout_reg   <= '0;
      din_reg    <= '0;
      irq_q      <= 1'b0;
    end else begin
      if (wr_idle) begin
        case (reg_addr)
          RAW'(A_CFG): begin
            cfg_ws     <= reg_wdata[WSW-1:0];
            cfg_irq_en <= reg_wdata[B_IRQEN];
            cfg_float  <= reg_wdata[B_FLOAT];
            cfg_slave  <= reg_wdata[B_SLAVE];
            cfg_rise   <= reg_wdata[B_RISE];
          end
          RAW'(A_CTL): begin
            ctl_buf <= reg_wdata[B_BUF];
            ctl_rd  <= reg_wdata[B_DIR];
          end
          RAW'(A_PTR):  ptr_reg  <= reg_wdata[AW-1:0];
          RAW'(A_LEN):  len_reg  <= reg_wdata[LW-1:0];
          RAW'(A_DOUT): dout_reg <= reg_wdata[7:0];
          default: ;
        endcase
      end
      if (ev_capture && !ctl_buf) din_reg <= nf_din;
      if (ev_finish && cfg_irq_en) irq_q <= 1'b1;
      else if (wr_ctl)             irq_q <= 1'b0;
    end
  end

  // transfer engine
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      strobe_n <= 1'b1;
      ptr_cur  <= '0;
      odd      <= 1'b0;
      remain   <= '0;
      wbyte    <= '0;
    end else begin
      if (ev_advance) begin
        odd    <= ~odd;
        remain <= remain - 1'b1;
        if (odd) ptr_cur <= ptr_cur + 1'b1;
      end
      case (st)
        ST_IDLE: if (ev_go) begin
          ptr_cur <= ptr_reg;
          odd     <= 1'b0;
          remain  <= start_cnt;
          wbyte   <= reg_wdata[B_BUF] ? lane_pick(mem_rdata, 1'b0) : dout_reg;
          if (cfg_slave) begin
            st <= ST_SLV;
          end else begin
            st       <= ST_LOW;
            strobe_n <= 1'b0;
          end
        end
        ST_LOW: if (term) begin
          st       <= ST_HIGH;
          strobe_n <= 1'b1;
        end
        ST_HIGH: if (term) begin
          if (remain == '0) begin
            st <= ST_IDLE;
          end else begin
            st       <= ST_LOW;
            strobe_n <= 1'b0;
            wbyte    <= ctl_buf ? lane_pick(mem_rdata, odd) : dout_reg;
          end
        end
        ST_SLV: if (slv_edge && (remain == LW'(1))) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // memory port
  assign mem_addr  = busy ? ptr_cur : ptr_reg;
  assign mem_we    = ev_capture && ctl_buf;
  assign mem_be    = lane_mask(odd);
  assign mem_wdata = {nf_din, nf_din};

  // flash pins
  logic master_wr;
  assign master_wr = ((st == ST_LOW) || (st == ST_HIGH)) && !ctl_rd;
  assign nf_re_n   = ctl_rd ? strobe_n : 1'b1;
  assign nf_we_n   = ctl_rd ? 1'b1 : strobe_n;
  assign nf_dout   = wbyte;
  assign nf_doe    = master_wr || !cfg_float;
  assign irq       = irq_q;

  // register read mux
  logic [CFGW-1:0] cfg_word;
  always_comb begin
    cfg_word = '0;
    cfg_word[WSW-1:0] = cfg_ws;
    cfg_word[B_IRQEN] = cfg_irq_en;
    cfg_word[B_FLOAT] = cfg_float;
    cfg_word[B_SLAVE] = cfg_slave;
    cfg_word[B_RISE]  = cfg_rise;
    reg_rdata = '0;
    case (reg_addr)
      RAW'(A_CFG): reg_rdata[CFGW-1:0] = cfg_word;
      RAW'(A_CTL): begin
        reg_rdata[B_BUF] = ctl_buf;
        reg_rdata[B_GO]  = busy;
        reg_rdata[B_DIR] = ctl_rd;
        reg_rdata[B_RDY] = rb_s;
      end
      RAW'(A_PTR):  reg_rdata[AW-1:0] = ptr_reg;
      RAW'(A_LEN):  reg_rdata[LW-1:0] = len_reg;
      RAW'(A_DIN):  reg_rdata[7:0]    = din_reg;
      RAW'(A_DOUT): reg_rdata[7:0]    = dout_reg;
      default: ;
    endcase
  end
endmodule

// File: rtl/nfx_chk.sv
module nfx_chk
  import nfx_pkg::*;
#(
  parameter int WSW = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           re_n,
  input logic           we_n,
  input logic           mem_we,
  input logic [1:0]     mem_be,
  input logic           irq,
  input logic           irq_en,
  input logic           finish,
  input logic [WSW-1:0] ws
);
  logic           strb_hi;
  logic [WSW:0]   low_cnt;
  logic [WSW:0]   want_len;

  assign strb_hi  = re_n & we_n;
  assign want_len = (WSW+1)'(phase_len(32'(ws)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       low_cnt <= '0;
    else if (strb_hi) low_cnt <= '0;
    else              low_cnt <= low_cnt + 1'b1;
  end

  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!re_n && !we_n));

  // R2
  low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strb_hi) |-> (low_cnt == want_len));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> strb_hi);

  // R3
  lane_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($countones(mem_be) == 1));

  // R3
  mem_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  // R5
  irq_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && irq_en) |=> irq);
endmodule

bind nand_xfer_ctrl nfx_chk #(.WSW(WSW)) chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .busy   (busy),
  .re_n   (nf_re_n),
  .we_n   (nf_we_n),
  .mem_we (mem_we),
  .mem_be (mem_be),
  .irq    (irq),
  .irq_en (cfg_irq_en),
  .finish (ev_finish),
  .ws     (cfg_ws)
);

// File: tb/nand_xfer_ctrl_tb_top.sv
module nand_xfer_ctrl_tb_top;
  localparam int AW = 8, LW = 16, WSW = 6, RAW = 3;
  localparam int A_CFG = 0, A_CTL = 1, A_PTR = 2, A_LEN = 3, A_DIN = 4, A_DOUT = 5;
  localparam int NV = 6;
  // {dir[31], ws[29:24], len[23:16], ptr[15:8], seed[7:0]}
  localparam logic [31:0] VEC [NV] = '{
    32'h80_04_10_11, 32'h82_05_20_22, 32'h00_04_30_33,
    32'h03_03_40_44, 32'h85_01_50_55, 32'h01_06_60_66
  };

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic           reg_we = 1'b0;
  logic [RAW-1:0] reg_addr = RAW'(A_CTL);
  logic [15:0]    reg_wdata = '0;
  wire  [15:0]    reg_rdata;
  wire  [AW-1:0]  mem_addr;
  wire            mem_we;
  wire  [1:0]     mem_be;
  wire  [15:0]    mem_wdata, mem_rdata;
  wire  [7:0]     nf_din, nf_dout;
  wire            nf_doe, nf_re_n, nf_we_n, irq;
  logic           nf_rb = 1'b1;

  logic       tb_slave = 1'b0;
  logic [7:0] slv_byte = '0, seed_tb = '0;
  int         re_rises = 0, re_base = 0, wcnt = 0;
  logic       re_q = 1'b1, we_q = 1'b1;
  logic [7:0] wlog [64];
  logic [15:0] ram [256];
  int tests = 0, fails = 0;

  function automatic logic [15:0] rom_word(input logic [AW-1:0] a);
    return {a ^ 8'h3C, a + 8'h51};
  endfunction

  assign mem_rdata = rom_word(mem_addr);
  assign nf_din    = tb_slave ? slv_byte : seed_tb + 8'(17 * (re_rises - re_base));

  nand_xfer_ctrl #(.AW(AW), .LW(LW), .WSW(WSW), .RAW(RAW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .nf_din(nf_din), .nf_dout(nf_dout),
    .nf_doe(nf_doe), .nf_re_n(nf_re_n), .nf_we_n(nf_we_n),
    .nf_rb(nf_rb), .irq(irq)
  );

  // memory model
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) ram[i] <= '0;
    end else if (mem_we) begin
      if (mem_be[1]) ram[mem_addr][15:8] <= mem_wdata[15:8];
      if (mem_be[0]) ram[mem_addr][7:0]  <= mem_wdata[7:0];
    end
  end

  // flash model: count read strobes, log bytes written
  always @(negedge clk) begin
    re_q <= nf_re_n;
    we_q <= nf_we_n;
    if (nf_re_n && !re_q) re_rises <= re_rises + 1;
    if (nf_we_n && !we_q) begin
      wlog[wcnt[5:0]] <= nf_dout;
      wcnt <= wcnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input int a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = RAW'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = RAW'(A_CTL);
    #1;
  endtask

  task automatic reg_rd(input int a, output logic [15:0] d);
    reg_addr = RAW'(a); #1;
    d = reg_rdata;
    reg_addr = RAW'(A_CTL); #1;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (reg_rdata[1] && n < 5000) begin
      n++;
      @(negedge clk); #1;
    end
  endtask

  task automatic slave_byte(input logic [7:0] b);
    slv_byte = b;
    @(negedge clk); nf_rb = 1'b0;
    repeat (6) @(negedge clk);
    nf_rb = 1'b1;
    repeat (6) @(negedge clk);
    #1;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;

    // R1 reset state
    reg_rd(A_CFG, rd);  chk("R1 cfg", rd, 0);
    reg_rd(A_CTL, rd);  chk("R1 ctl", rd, 16'h0010);
    reg_rd(A_PTR, rd);  chk("R1 ptr", rd, 0);
    reg_rd(A_LEN, rd);  chk("R1 len", rd, 0);
    reg_rd(A_DIN, rd);  chk("R1 din", rd, 0);
    reg_rd(A_DOUT, rd); chk("R1 dout", rd, 0);
    chk("R1 pins", {irq, nf_re_n, nf_we_n, nf_doe}, 4'b0111);

    // R9 synchronizer latency
    @(negedge clk); nf_rb = 1'b0;
    @(negedge clk); #1; chk("R9 rdy after 1 edge", reg_rdata[4], 1);
    @(negedge clk); #1; chk("R9 rdy after 2 edges", reg_rdata[4], 0);
    nf_rb = 1'b1;
    repeat (3) @(negedge clk); #1;
    chk("R9 rdy back high", reg_rdata[4], 1);

    // table of buffered master transfers: R2 R3 R4 R5 R8
    for (int v = 0; v < NV; v++) begin
      logic dir; int ws, len; logic [7:0] ptr, seed; int wbase;
      dir = VEC[v][31]; ws = int'(VEC[v][29:24]); len = int'(VEC[v][23:16]);
      ptr = VEC[v][15:8]; seed = VEC[v][7:0];
      seed_tb = seed; re_base = re_rises; wbase = wcnt;
      reg_wr(A_CFG, 16'h00C0 | 16'(ws));
      reg_wr(A_PTR, 16'(ptr));
      reg_wr(A_LEN, 16'(len));
      reg_wr(A_CTL, {13'b0, dir, 2'b11});
      chk("R8 doe during transfer", nf_doe, !dir);
      wait_idle(n);
      chk("R2 transfer cycles", n, len * 2 * (ws + 1));
      chk("R5 irq after done", irq, 1);
      if (dir) begin
        for (int k = 0; k < len; k++) begin
          logic [15:0] w;
          w = ram[ptr + 8'(k / 2)];
          chk("R3 read byte lane", (k % 2) ? w[7:0] : w[15:8], 8'(seed + 8'(17 * k)));
        end
        if (len % 2) chk("R3 untouched lane", ram[ptr + 8'(len / 2)][7:0], 0);
      end else begin
        chk("R4 write byte count", wcnt - wbase, len);
        for (int k = 0; k < len; k++) begin
          logic [15:0] w;
          w = rom_word(ptr + 8'(k / 2));
          chk("R4 write byte lane", wlog[6'(wbase + k)], (k % 2) ? w[7:0] : w[15:8]);
        end
      end
    end

    // R5 irq cleared by a control write
    reg_wr(A_CTL, 16'h0000);
    chk("R5 irq cleared", irq, 0);

    // R6 zero length
    reg_wr(A_CFG, 16'h00C0);
    reg_wr(A_LEN, 16'h0000);
    re_base = re_rises;
    reg_wr(A_CTL, 16'h0007);
    chk("R6 go cleared", reg_rdata[1], 0);
    chk("R6 irq raised", irq, 1);
    repeat (3) @(negedge clk); #1;
    chk("R6 no strobe", re_rises - re_base, 0);

    // R11 interrupt disabled
    reg_wr(A_CFG, 16'h0080);
    reg_wr(A_PTR, 16'h0090);
    reg_wr(A_LEN, 16'h0002);
    reg_wr(A_CTL, 16'h0007);
    wait_idle(n);
    chk("R11 done", n, 4);
    chk("R11 irq stays low", irq, 0);

    // R7 unbuffered read ignores length and memory
    seed_tb = 8'h3E; re_base = re_rises;
    reg_wr(A_CFG, 16'h00C1);
    reg_wr(A_PTR, 16'h00A0);
    reg_wr(A_LEN, 16'h0005);
    reg_wr(A_CTL, 16'h0006);
    wait_idle(n);
    chk("R7 one byte read", n, 4);
    reg_rd(A_DIN, rd);
    chk("R7 din byte", rd, 16'h003E);
    chk("R7 memory untouched", ram[8'hA0], 0);

    // R7 unbuffered write from output byte register
    begin
      int wbase;
      wbase = wcnt;
      reg_wr(A_DOUT, 16'h005A);
      reg_wr(A_CTL, 16'h0002);
      wait_idle(n);
      chk("R7 one byte write", wcnt - wbase, 1);
      chk("R7 dout byte sent", wlog[6'(wbase)], 8'h5A);
    end

    // R8 float select while idle
    reg_wr(A_CFG, 16'h0000);
    chk("R8 driven when float clear", nf_doe, 1);
    reg_wr(A_CFG, 16'h0080);
    chk("R8 floating when set", nf_doe, 0);

    // R10 slave capture on rising edge
    tb_slave = 1'b1;
    re_base = re_rises;
    reg_wr(A_CFG, 16'h03C0);
    reg_wr(A_PTR, 16'h0070);
    reg_wr(A_LEN, 16'h0003);
    reg_wr(A_CTL, 16'h0003);
    slave_byte(8'h11);
    slave_byte(8'h22);
    chk("R10 busy before last edge", reg_rdata[1], 1);
    slave_byte(8'h33);
    chk("R10 go cleared", reg_rdata[1], 0);
    chk("R10 irq", irq, 1);
    chk("R10 rise word0", ram[8'h70], 16'h1122);
    chk("R10 rise word1 upper", ram[8'h71][15:8], 8'h33);
    chk("R10 no read strobes", re_rises - re_base, 0);

    // R10 slave capture on falling edge
    reg_wr(A_CFG, 16'h01C0);
    reg_wr(A_PTR, 16'h0080);
    reg_wr(A_LEN, 16'h0002);
    reg_wr(A_CTL, 16'h0003);
    slave_byte(8'h44);
    slave_byte(8'h55);
    chk("R10 fall go cleared", reg_rdata[1], 0);
    chk("R10 fall word", ram[8'h80], 16'h4455);
    tb_slave = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule